// File: doc/BRIEF.md
# Machine Trap Value Generator

This block turns a single-cycle exception report into the pair of values that a trap handler sees: a cause code and a 32-bit trap value. The reporting unit states what kind of exception occurred and supplies every piece of context that might be needed: the instruction address, the raw instruction word, a two-bit fetch fault flag, a data effective address, a jump target, and the decoded fields of a system instruction. The block picks the right source for the kind, does the small arithmetic or re-encoding that kind needs, and registers the result.

Two kinds need more than a multiplexer. The first is a fetch fault that hit only the upper half of a 4-byte instruction at a 2-byte-aligned address: the trap value is then the instruction address plus two. The second is an access to a missing CSR or an illegal return/wait instruction. These units only keep decoded fields, so the original 32-bit instruction word is rebuilt from those fields. A handler can then emulate the instruction without fetching it again.

The result appears one cycle after the report with a one-cycle valid strobe. Between reports the outputs keep their last values.

Top module: `trapval_gen`

## Requirements
- R1: Kind codes 0, 1, 2, 3 (load access fault, store access fault, load misaligned, store misaligned) give causes 5, 7, 4, 6 in that order, and the trap value is `rpt_addr`.
- R2: Kind 4 (breakpoint) gives cause 3, and the trap value is `rpt_pc`.
- R3: Kind 5 (environment call from machine mode) gives cause 11 and kind 6 (from user mode) gives cause 8. Both give a trap value of zero.
- R4: Kind 7 (instruction access fault) gives cause 1. The trap value is `rpt_pc + 2` when bit 1 of `rpt_fetch_flag` (second-half fault) is set. Otherwise it is `rpt_pc`, including when only bit 0 (whole or first-half fault) is set.
- R5: Kind 8 (instruction page fault) gives cause 12 and uses the same plus-two rule as R4.
- R6: Kind 9 (illegal instruction at decode) gives cause 2, and the trap value is `rpt_instr` passed through unchanged. This includes 16-bit patterns whose low two bits are not 11.
- R7: Kind 10 (missing CSR) gives cause 2. The trap value has these fields: bits 1:0 = 11, bits 6:2 = 11100, bits 11:7 = `rpt_rd`, bits 14:12 = `rpt_funct3`, bits 19:15 = `rpt_src` (register number or 5-bit immediate), bits 31:20 = `rpt_csr`.
- R8: Kind 11 (illegal privileged return/wait) gives cause 2. The trap value is 0x30200073 when `rpt_priv_wfi` is 0 and 0x10500073 when it is 1.
- R9: Kind 12 (jump or taken-branch target misaligned) gives cause 0, and the trap value is `rpt_target`.
- R10: Kind 13 (interrupt insertion point) gives cause 30 and kind 14 (misprediction redirect) gives cause 31. Both give a trap value of zero, whatever the other inputs are.
- R11: Kind 15 (not assigned) gives cause 2 with a trap value of zero.
- R12: `out_valid` is high in exactly the cycle after a cycle with `rpt_valid` high, and `out_cause` and `out_tval` update then. In a cycle after one without a report, all three hold their previous values, except that `out_valid` is low.
- R13: Synchronous reset sets `out_valid`, `out_cause` and `out_tval` to zero, even when a report is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rpt_valid | input | 1 | A report is present this cycle |
| rpt_kind | input | 4 | Exception kind code (see requirements) |
| rpt_pc | input | 32 | Address of the trapping instruction |
| rpt_instr | input | 32 | Raw instruction bits from decode |
| rpt_fetch_flag | input | 2 | Bit 0: whole/first-half fetch fault; bit 1: second-half fault |
| rpt_addr | input | 32 | Data effective address |
| rpt_target | input | 32 | Computed jump or branch target |
| rpt_rd | input | 5 | Destination register of the system instruction |
| rpt_src | input | 5 | Source register or 5-bit immediate |
| rpt_funct3 | input | 3 | Minor opcode of the system instruction |
| rpt_csr | input | 12 | CSR address field |
| rpt_priv_wfi | input | 1 | 1: trapping instruction was wait, 0: return |
| out_valid | output | 1 | Result valid strobe |
| out_cause | output | 5 | Registered cause code |
| out_tval | output | 32 | Registered trap value |

## Verification
The bench covers the three places where the trap value is computed rather than copied.

The plus-two adjustment is driven with only the first-half flag, only the second-half flag, and both. A design that tested the wrong flag bit, or ORed the two bits together, would report the wrong address for one of these.

The rebuilt CSR and privileged encodings are checked against known complete words. A field packed in the wrong position, or the return and wait function codes swapped, would change the full word.

The pseudo-causes and the unassigned kind are driven with nonzero values on every context input. A design that let one of those inputs through would give a trap value other than zero. The hold and reset cases show whether the outputs stay put between reports and whether reset takes priority over a report.

// File: rtl/trapval_pkg.sv
package trapval_pkg;

  typedef enum logic [3:0] {
    K_LOAD_ACC     = 4'd0,
    K_STORE_ACC    = 4'd1,
    K_LOAD_MIS     = 4'd2,
    K_STORE_MIS    = 4'd3,
    K_BREAK        = 4'd4,
    K_ECALL_M      = 4'd5,
    K_ECALL_U      = 4'd6,
    K_FETCH_ACC    = 4'd7,
    K_FETCH_PAGE   = 4'd8,
    K_ILLEGAL      = 4'd9,
    K_CSR_MISSING  = 4'd10,
    K_PRIV_ILLEGAL = 4'd11,
    K_JUMP_MIS     = 4'd12,
    K_INT_IRQ      = 4'd13,
    K_INT_REDIRECT = 4'd14,
    K_RESERVED     = 4'd15
  } kind_e;

  localparam int KIND_W  = 4;
  localparam int CAUSE_W = 5;
  localparam int ENC_W   = 32;

  localparam logic [CAUSE_W-1:0] C_JUMP_MIS   = 5'd0;
  localparam logic [CAUSE_W-1:0] C_FETCH_ACC  = 5'd1;
  localparam logic [CAUSE_W-1:0] C_ILLEGAL    = 5'd2;
  localparam logic [CAUSE_W-1:0] C_BREAK      = 5'd3;
  localparam logic [CAUSE_W-1:0] C_LOAD_MIS   = 5'd4;
  localparam logic [CAUSE_W-1:0] C_LOAD_ACC   = 5'd5;
  localparam logic [CAUSE_W-1:0] C_STORE_MIS  = 5'd6;
  localparam logic [CAUSE_W-1:0] C_STORE_ACC  = 5'd7;
  localparam logic [CAUSE_W-1:0] C_ECALL_U    = 5'd8;
  localparam logic [CAUSE_W-1:0] C_ECALL_M    = 5'd11;
  localparam logic [CAUSE_W-1:0] C_FETCH_PAGE = 5'd12;
  localparam logic [CAUSE_W-1:0] C_INT_IRQ    = 5'd30;
  localparam logic [CAUSE_W-1:0] C_INT_REDIR  = 5'd31;

  localparam logic [1:0]  ENC_LEN32   = 2'b11;
  localparam logic [4:0]  ENC_SYSTEM  = 5'b11100;
  localparam logic [11:0] F12_RETURN  = 12'h302;
  localparam logic [11:0] F12_WAIT    = 12'h105;

  // Pack the fields of a system-opcode instruction word.
  function automatic logic [ENC_W-1:0] sys_word(
    input logic [4:0]  rd,
    input logic [2:0]  f3,
    input logic [4:0]  src,
    input logic [11:0] f12
  );
    return {f12, src, f3, rd, ENC_SYSTEM, ENC_LEN32};
  endfunction

  // Choose the function code of an illegal privileged instruction.
  function automatic logic [11:0] priv_f12(input logic is_wait);
    return is_wait ? F12_WAIT : F12_RETURN;
  endfunction

endpackage

// File: rtl/trapval_pcadj.sv
module trapval_pcadj #(
  parameter int XLEN       = 32,
  parameter int HALF_BYTES = 2
) (
  input  logic [XLEN-1:0] pc,
  input  logic [1:0]      flag,
  output logic [XLEN-1:0] adj_pc,
  output logic            upper_half
);
  localparam logic [XLEN-1:0] STEP = XLEN'(HALF_BYTES);

  assign upper_half = flag[1];
  assign adj_pc     = upper_half ? (pc + STEP) : pc;
endmodule

// File: rtl/trapval_sysenc.sv
module trapval_sysenc #(
  parameter int XLEN = 32
) (
  input  logic            is_priv,
  input  logic [4:0]      rd,
  input  logic [4:0]      src,
  input  logic [2:0]      funct3,
  input  logic [11:0]     csr,
  input  logic            priv_wait,
  output logic [XLEN-1:0] word
);
  import trapval_pkg::*;

  logic [ENC_W-1:0] csr_word;
  logic [ENC_W-1:0] priv_word;

  assign csr_word  = sys_word(rd, funct3, src, csr);
  assign priv_word = sys_word(5'd0, 3'd0, 5'd0, priv_f12(priv_wait));
  assign word      = XLEN'(is_priv ? priv_word : csr_word);
endmodule

// File: rtl/trapval_mux.sv
module trapval_mux #(
  parameter int XLEN = 32
) (
  input  logic [trapval_pkg::KIND_W-1:0]   kind,
  input  logic [XLEN-1:0]                  pc,
  input  logic [XLEN-1:0]                  instr,
  input  logic [XLEN-1:0]                  addr,
  input  logic [XLEN-1:0]                  target,
  input  logic [XLEN-1:0]                  fetch_pc,
  input  logic [XLEN-1:0]                  sys_enc,
  output logic [trapval_pkg::CAUSE_W-1:0]  cause,
  output logic [XLEN-1:0]                  value,
  output logic                             known
);
  import trapval_pkg::*;

  always_comb begin
    cause = C_ILLEGAL;
    value = '0;
    known = 1'b1;
    case (kind_e'(kind))
      K_LOAD_ACC:     begin cause = C_LOAD_ACC;   value = addr;     end
      K_STORE_ACC:    begin cause = C_STORE_ACC;  value = addr;     end
      K_LOAD_MIS:     begin cause = C_LOAD_MIS;   value = addr;     end
      K_STORE_MIS:    begin cause = C_STORE_MIS;  value = addr;     end
      K_BREAK:        begin cause = C_BREAK;      value = pc;       end
      K_ECALL_M:      begin cause = C_ECALL_M;    value = '0;       end
      K_ECALL_U:      begin cause = C_ECALL_U;    value = '0;       end
      K_FETCH_ACC:    begin cause = C_FETCH_ACC;  value = fetch_pc; end
      K_FETCH_PAGE:   begin cause = C_FETCH_PAGE; value = fetch_pc; end
      K_ILLEGAL:      begin cause = C_ILLEGAL;    value = instr;    end
      K_CSR_MISSING:  begin cause = C_ILLEGAL;    value = sys_enc;  end
      K_PRIV_ILLEGAL: begin cause = C_ILLEGAL;    value = sys_enc;  end
      K_JUMP_MIS:     begin cause = C_JUMP_MIS;   value = target;   end
      K_INT_IRQ:      begin cause = C_INT_IRQ;    value = '0;       end
      K_INT_REDIRECT: begin cause = C_INT_REDIR;  value = '0;       end
      default:        begin cause = C_ILLEGAL;    value = '0; known = 1'b0; end
    endcase
  end
endmodule

// File: rtl/trapval_gen.sv
module trapval_gen #(
  parameter int XLEN = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rpt_valid,
  input  logic [trapval_pkg::KIND_W-1:0]   rpt_kind,
  input  logic [XLEN-1:0]                  rpt_pc,
  input  logic [XLEN-1:0]                  rpt_instr,
  input  logic [1:0]                       rpt_fetch_flag,
  input  logic [XLEN-1:0]                  rpt_addr,
  input  logic [XLEN-1:0]                  rpt_target,
  input  logic [4:0]                       rpt_rd,
  input  logic [4:0]                       rpt_src,
  input  logic [2:0]                       rpt_funct3,
  input  logic [11:0]                      rpt_csr,
  input  logic                             rpt_priv_wfi,
  output logic                             out_valid,
  output logic [trapval_pkg::CAUSE_W-1:0]  out_cause,
  output logic [XLEN-1:0]                  out_tval
);
  import trapval_pkg::*;

  // Named internal events for the checker.
  logic [XLEN-1:0]    fetch_pc;
  logic               fetch_upper;
  logic               is_priv_kind;
  logic [XLEN-1:0]    sys_enc;
  logic [CAUSE_W-1:0] sel_cause;
  logic [XLEN-1:0]    sel_tval;
  logic               sel_known;

  assign is_priv_kind = (kind_e'(rpt_kind) == K_PRIV_ILLEGAL);

  trapval_pcadj #(.XLEN(XLEN), .HALF_BYTES(2)) u_pcadj (
    .pc         (rpt_pc),
    .flag       (rpt_fetch_flag),
    .adj_pc     (fetch_pc),
    .upper_half (fetch_upper)
  );

  trapval_sysenc #(.XLEN(XLEN)) u_sysenc (
    .is_priv   (is_priv_kind),
    .rd        (rpt_rd),
    .src       (rpt_src),
    .funct3    (rpt_funct3),
    .csr       (rpt_csr),
    .priv_wait (rpt_priv_wfi),
    .word      (sys_enc)
  );

  trapval_mux #(.XLEN(XLEN)) u_mux (
    .kind     (rpt_kind),
    .pc       (rpt_pc),
    .instr    (rpt_instr),
    .addr     (rpt_addr),
    .target   (rpt_target),
    .fetch_pc (fetch_pc),
    .sys_enc  (sys_enc),
    .cause    (sel_cause),
    .value    (sel_tval),
    .known    (sel_known)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_cause <= '0;
      out_tval  <= '0;
    end else begin
      out_valid <= rpt_valid;
      if (rpt_valid) begin
        out_cause <= sel_cause;
        out_tval  <= sel_tval;
      end
    end
  end
endmodule

// File: rtl/trapval_gen_chk.sv
module trapval_gen_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            rpt_valid,
  input logic [3:0]      rpt_kind,
  input logic [XLEN-1:0] rpt_pc,
  input logic [XLEN-1:0] rpt_addr,
  input logic [1:0]      rpt_fetch_flag,
  input logic [11:0]     rpt_csr,
  input logic            out_valid,
  input logic [4:0]      out_cause,
  input logic [XLEN-1:0] out_tval,
  input logic [XLEN-1:0] sel_tval,
  input logic            sel_known,
  input logic            fetch_upper
);

  // R12: strobe follows the report by one cycle
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |=> out_valid);
  a_r12_no_report_low: assert property (@(posedge clk) disable iff (rst)
    !rpt_valid |=> !out_valid);
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !rpt_valid |=> ($stable(out_cause) && $stable(out_tval)));
  a_r12_register_path: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |=> out_tval == $past(sel_tval));

  // R1: memory faults report the data address
  a_r1_mem_addr: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_kind <= 4'd3) |=> out_tval == $past(rpt_addr));

  // R3: environment calls carry zero
  a_r3_ecall_zero: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && (rpt_kind == 4'd5 || rpt_kind == 4'd6)) |=> out_tval == '0);

  // R4: first-half-only fetch fault reports the instruction address
  a_r4_first_half: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_kind == 4'd7 && rpt_fetch_flag == 2'b01) |=> out_tval == $past(rpt_pc));
  a_r4_upper_event: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_kind == 4'd7 && fetch_upper) |=> out_tval == $past(rpt_pc) + XLEN'(2));

  // R7: rebuilt CSR word has the system opcode and the CSR address
  a_r7_csr_frame: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_kind == 4'd10) |=>
      (out_tval[6:0] == 7'h73 && out_tval[31:20] == $past(rpt_csr)));

  // R10: pseudo-causes carry zero
  a_r10_internal_zero: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && (rpt_kind == 4'd13 || rpt_kind == 4'd14)) |=> out_tval == '0);

  // R11: unassigned kind
  a_r11_unknown: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && !sel_known) |=> (out_cause == 5'd2 && out_tval == '0));

  // R13: reset clears the strobe
  a_r13_reset: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

bind trapval_gen trapval_gen_chk #(.XLEN(XLEN)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .rpt_valid      (rpt_valid),
  .rpt_kind       (rpt_kind),
  .rpt_pc         (rpt_pc),
  .rpt_addr       (rpt_addr),
  .rpt_fetch_flag (rpt_fetch_flag),
  .rpt_csr        (rpt_csr),
  .out_valid      (out_valid),
  .out_cause      (out_cause),
  .out_tval       (out_tval),
  .sel_tval       (sel_tval),
  .sel_known      (sel_known),
  .fetch_upper    (fetch_upper)
);

// File: tb/trapval_gen_tb.sv
`timescale 1ns/1ps
module trapval_gen_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        rpt_valid;
  logic [3:0]  rpt_kind;
  logic [31:0] rpt_pc, rpt_instr, rpt_addr, rpt_target;
  logic [1:0]  rpt_fetch_flag;
  logic [4:0]  rpt_rd, rpt_src;
  logic [2:0]  rpt_funct3;
  logic [11:0] rpt_csr;
  logic        rpt_priv_wfi;
  logic        out_valid;
  logic [4:0]  out_cause;
  logic [31:0] out_tval;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  trapval_gen u_dut (
    .clk(clk), .rst(rst), .rpt_valid(rpt_valid), .rpt_kind(rpt_kind),
    .rpt_pc(rpt_pc), .rpt_instr(rpt_instr), .rpt_fetch_flag(rpt_fetch_flag),
    .rpt_addr(rpt_addr), .rpt_target(rpt_target), .rpt_rd(rpt_rd),
    .rpt_src(rpt_src), .rpt_funct3(rpt_funct3), .rpt_csr(rpt_csr),
    .rpt_priv_wfi(rpt_priv_wfi), .out_valid(out_valid),
    .out_cause(out_cause), .out_tval(out_tval)
  );

  task automatic expect_out(input string req, input logic v, input logic [4:0] c, input logic [31:0] t);
    checks++;
    if (out_valid !== v || out_cause !== c || out_tval !== t) begin
      fails++;
      $display("FAIL %s: got valid=%0b cause=%0d tval=%h, expected valid=%0b cause=%0d tval=%h",
               req, out_valid, out_cause, out_tval, v, c, t);
    end
  endtask

  // Fill context inputs with distinct nonzero junk.
  task automatic junk();
    rpt_pc = 32'h0000_4A10; rpt_instr = 32'hDEAD_BEEF; rpt_addr = 32'h1234_5678;
    rpt_target = 32'h0000_9002; rpt_fetch_flag = 2'b11; rpt_rd = 5'd9;
    rpt_src = 5'd17; rpt_funct3 = 3'd6; rpt_csr = 12'hABC; rpt_priv_wfi = 1'b1;
  endtask

  // Present one report, return at the negedge after the capturing edge.
  task automatic fire(input logic [3:0] k);
    @(negedge clk);
    rpt_kind = k; rpt_valid = 1'b1;
    @(negedge clk);
    rpt_valid = 1'b0;
  endtask

  task automatic t_reset();
    expect_out("R13 reset state", 1'b0, 5'd0, 32'h0);
  endtask

  task automatic t_mem();
    junk(); rpt_addr = 32'h8000_0230; fire(4'd0);
    expect_out("R1 load access", 1'b1, 5'd5, 32'h8000_0230);
    rpt_addr = 32'h0000_0FF8; fire(4'd1);
    expect_out("R1 store access", 1'b1, 5'd7, 32'h0000_0FF8);
    rpt_addr = 32'h0000_0013; fire(4'd2);
    expect_out("R1 load misaligned", 1'b1, 5'd4, 32'h0000_0013);
    rpt_addr = 32'h8000_0231; fire(4'd3);
    expect_out("R1 store misaligned", 1'b1, 5'd6, 32'h8000_0231);
  endtask

  task automatic t_break();
    junk(); rpt_pc = 32'h0000_0104; fire(4'd4);
    expect_out("R2 breakpoint", 1'b1, 5'd3, 32'h0000_0104);
  endtask

  task automatic t_ecall();
    junk(); fire(4'd5);
    expect_out("R3 ecall machine", 1'b1, 5'd11, 32'h0);
    fire(4'd6);
    expect_out("R3 ecall user", 1'b1, 5'd8, 32'h0);
  endtask

  task automatic t_fetch();
    junk(); rpt_pc = 32'h0000_0FFE;
    rpt_fetch_flag = 2'b01; fire(4'd7);
    expect_out("R4 first-half fault", 1'b1, 5'd1, 32'h0000_0FFE);
    rpt_fetch_flag = 2'b10; fire(4'd7);
    expect_out("R4 second-half fault", 1'b1, 5'd1, 32'h0000_1000);
    rpt_fetch_flag = 2'b11; fire(4'd7);
    expect_out("R4 both flags", 1'b1, 5'd1, 32'h0000_1000);
    rpt_pc = 32'hFFFF_FFFE; rpt_fetch_flag = 2'b10; fire(4'd8);
    expect_out("R5 page fault upper half", 1'b1, 5'd12, 32'h0000_0000);
    rpt_pc = 32'h0000_2000; rpt_fetch_flag = 2'b01; fire(4'd8);
    expect_out("R5 page fault whole", 1'b1, 5'd12, 32'h0000_2000);
  endtask

  task automatic t_illegal();
    junk(); rpt_instr = 32'h0000_8000; fire(4'd9);
    expect_out("R6 compressed pattern", 1'b1, 5'd2, 32'h0000_8000);
    rpt_instr = 32'h0000_0043; fire(4'd9);
    expect_out("R6 full word", 1'b1, 5'd2, 32'h0000_0043);
  endtask

  task automatic t_csr();
    junk(); rpt_rd = 5'd1; rpt_src = 5'd0; rpt_funct3 = 3'd2; rpt_csr = 12'h123;
    fire(4'd10);
    expect_out("R7 csr read", 1'b1, 5'd2, 32'h1230_20F3);
    rpt_rd = 5'd0; rpt_src = 5'd8; rpt_funct3 = 3'd5; fire(4'd10);
    expect_out("R7 csr immediate write", 1'b1, 5'd2, 32'h1234_5073);
    rpt_rd = 5'd31; rpt_src = 5'd31; rpt_funct3 = 3'd7; rpt_csr = 12'hFFF; fire(4'd10);
    expect_out("R7 all fields high", 1'b1, 5'd2, 32'hFFFF_FFF3);
  endtask

  task automatic t_priv();
    junk(); rpt_priv_wfi = 1'b0; fire(4'd11);
    expect_out("R8 return", 1'b1, 5'd2, 32'h3020_0073);
    rpt_priv_wfi = 1'b1; fire(4'd11);
    expect_out("R8 wait", 1'b1, 5'd2, 32'h1050_0073);
  endtask

  task automatic t_jump();
    junk(); rpt_target = 32'h0000_0456; fire(4'd12);
    expect_out("R9 jump target", 1'b1, 5'd0, 32'h0000_0456);
  endtask

  task automatic t_internal();
    junk(); fire(4'd13);
    expect_out("R10 interrupt insertion", 1'b1, 5'd30, 32'h0);
    fire(4'd14);
    expect_out("R10 redirect", 1'b1, 5'd31, 32'h0);
    fire(4'd15);
    expect_out("R11 unassigned kind", 1'b1, 5'd2, 32'h0);
  endtask

  task automatic t_hold();
    junk(); rpt_addr = 32'hCAFE_0004; fire(4'd1);
    expect_out("R12 captured", 1'b1, 5'd7, 32'hCAFE_0004);
    rpt_kind = 4'd4; rpt_pc = 32'h0000_7770; rpt_addr = 32'h0;
    @(negedge clk);
    expect_out("R12 hold after strobe", 1'b0, 5'd7, 32'hCAFE_0004);
    @(negedge clk);
    expect_out("R12 hold second cycle", 1'b0, 5'd7, 32'hCAFE_0004);
  endtask

  task automatic t_reset_priority();
    junk(); rpt_addr = 32'h0BAD_0000;
    @(negedge clk);
    rst = 1'b1; rpt_kind = 4'd0; rpt_valid = 1'b1;
    @(negedge clk);
    rst = 1'b0; rpt_valid = 1'b0;
    expect_out("R13 reset beats report", 1'b0, 5'd0, 32'h0);
  endtask

  initial begin
    rst = 1'b1; rpt_valid = 1'b0; rpt_kind = 4'd0; junk();
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_mem();
    t_break();
    t_ecall();
    t_fetch();
    t_illegal();
    t_csr();
    t_priv();
    t_jump();
    t_internal();
    t_hold();
    t_reset_priority();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule